// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block receives asynchronous serial frames on one input line for a node on a shared multi-drop bus. A programmable divisor and a speed-range select set the rate of a tick at sixteen times the bit rate. A front end driven by that tick finds each start bit and takes three samples around the middle of every bit. A shift stage then builds an 8-bit or 9-bit frame, least significant bit first. Finished frames are stored in a two-entry queue. Each entry keeps its own framing-error mark. Software reads the entries through a register-style port: data, ninth bit and framing error are shown for the head entry, and a read strobe pops it.

In 9-bit mode the address filter can be switched on. The node then stores only frames whose ninth bit is 1, which are the address frames on the bus. Software watches for its own address and then switches the filter off to receive the data that follows. A frame that finishes while the queue is full sets an overrun flag. From then on every frame is dropped until the receive enable is cleared. An interrupt output follows data-available whenever the interrupt enable is set.

Top module: `uart_rx_addr`

## Requirements
- R1: The oversample tick period is divisor_i+1 clocks when hi_speed_i=1 and 4*(divisor_i+1) clocks when hi_speed_i=0. One bit lasts 16 ticks.
- R2: No frame is received while port_en_i=0 or rx_en_i=0.
- R3: In 8-bit mode (nine_bit_i=0) the frame is a 0 start bit, 8 data bits LSB first and a stop bit. The data appears on rd_data_o and rd_bit8_o reads 0.
- R4: In 9-bit mode a ninth data bit follows the eighth and appears on rd_bit8_o.
- R5: With addr_det_i=1 and nine_bit_i=1, a frame whose ninth bit is 0 is dropped and one whose ninth bit is 1 is stored. With nine_bit_i=0, addr_det_i has no effect.
- R6: A stop bit sampled as 0 sets rd_ferr_o for that frame's entry only.
- R7: The queue holds two frames in arrival order. A pulse on rd_i pops the head entry.
- R8: A frame that is accepted while the queue is full and not being read sets overrun_o and is dropped. While overrun_o=1, every frame is dropped. Clearing rx_en_i clears overrun_o.
- R9: avail_o is 1 while the queue holds a frame and returns to 0 after the read that empties it. irq_o equals avail_o AND irq_en_i.
- R10: A low pulse on the line that is back high at mid-bit is not taken as a start bit.
- R11: Each bit is the majority of three samples around mid-bit, so a line glitch shorter than one tick does not change a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idles high |
| port_en_i | input | 1 | Port enable |
| rx_en_i | input | 1 | Continuous receive enable |
| hi_speed_i | input | 1 | 1: tick every divisor+1 clocks; 0: every 4*(divisor+1) clocks |
| divisor_i | input | DIV_W | Baud divisor |
| nine_bit_i | input | 1 | 9-bit frame mode |
| addr_det_i | input | 1 | Address filter enable (9-bit mode only) |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Pop the head queue entry |
| rd_data_o | output | 8 | Head entry data |
| rd_bit8_o | output | 1 | Head entry ninth bit |
| rd_ferr_o | output | 1 | Head entry framing error |
| avail_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Receive interrupt |

## Verification
A frame reaches the queue at the tenth tick of its stop bit. It is visible at the outputs on the next clock edge, together with any overrun it causes. A pop and a change of irq_en_i show up one edge and zero edges later, respectively. The bench therefore sends the whole stop bit and then a further bit time of idle line before it looks at the head entry. It drives and samples only on falling clock edges, and it checks the result of each pop at the next falling edge. For a dropped frame, the bench checks after the same delay that avail_o and the head entry have not changed.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  typedef struct packed {
    logic       ferr;
    logic       bit8;
    logic [7:0] data;
  } rx_frame_t;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;
endpackage

// File: rtl/uart_rx_baud.sv
`timescale 1ns/1ps
module uart_rx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hi_speed_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q, limit;

  // low range: 4*(div+1)-1 = {div,2'b11}
  always_comb limit = hi_speed_i ? {2'b00, divisor_i} : {divisor_i, 2'b11};
  assign tick_o = !clr_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && limit != '0) |=> !tick_o);
endmodule

// File: rtl/uart_rx_core.sv
`timescale 1ns/1ps
module uart_rx_core
  import uart_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      nine_bit_i,
  input  logic      rxd_i,
  input  logic      tick_i,
  output logic      baud_clr_o,
  output logic      frame_vld_o,
  output rx_frame_t frame_o
);
  logic [2:0] sync_q;
  logic       line, fall, vote;
  rx_state_e  state_q;
  logic [3:0] scnt_q, idx_q, last_idx;
  logic [1:0] samp_q;
  logic [8:0] shift_q;
  logic       vld_q;
  rx_frame_t  frame_q;

  assign line     = sync_q[1];
  assign fall     = sync_q[2] & ~sync_q[1];
  assign vote     = (samp_q[0] & samp_q[1]) | (samp_q[0] & line) | (samp_q[1] & line);
  assign last_idx = nine_bit_i ? 4'd8 : 4'd7;

  // realign oversample phase to the detected start edge
  assign baud_clr_o  = (state_q == ST_IDLE) && en_i && fall;
  assign frame_vld_o = vld_q;
  assign frame_o     = frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      idx_q   <= '0;
      samp_q  <= '0;
      shift_q <= '0;
      vld_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (state_q == ST_IDLE) begin
        if (fall) begin
          state_q <= ST_START;
          scnt_q  <= '0;
          idx_q   <= '0;
          shift_q <= '0;
        end
      end else if (tick_i) begin
        scnt_q <= scnt_q + 1'b1;
        if (scnt_q == 4'd7) samp_q[0] <= line;
        if (scnt_q == 4'd8) samp_q[1] <= line;
        if (scnt_q == 4'd9) begin
          unique case (state_q)
            ST_START: if (vote) state_q <= ST_IDLE;
            ST_DATA:  shift_q[idx_q] <= vote;
            ST_STOP: begin
              vld_q         <= 1'b1;
              frame_q.ferr  <= !vote;
              frame_q.bit8  <= nine_bit_i & shift_q[8];
              frame_q.data  <= shift_q[7:0];
              state_q       <= ST_IDLE;
            end
            default: ;
          endcase
        end
        if (scnt_q == 4'd15) begin
          unique case (state_q)
            ST_START: state_q <= ST_DATA;
            ST_DATA: begin
              if (idx_q == last_idx) state_q <= ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_off_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE));
  p_vld_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
  p_vld_from_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign dout_o  = mem_q[rd_q];
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      if (push_i && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && do_pop) cnt_q <= cnt_q - 1'b1;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o);
  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_rx_addr.sv
`timescale 1ns/1ps
module uart_rx_addr
  import uart_rx_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int FIFO_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic             port_en_i,
  input  logic             rx_en_i,
  input  logic             hi_speed_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             nine_bit_i,
  input  logic             addr_det_i,
  input  logic             irq_en_i,
  input  logic             rd_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_bit8_o,
  output logic             rd_ferr_o,
  output logic             avail_o,
  output logic             overrun_o,
  output logic             irq_o
);
  localparam int FRAME_W = $bits(rx_frame_t);

  logic      rx_on, tick, baud_clr, frame_vld, accept, space, push, empty, full, ovr_q;
  rx_frame_t frame, head;

  assign rx_on = port_en_i & rx_en_i;

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni,
    .clr_i      (baud_clr),
    .hi_speed_i,
    .divisor_i,
    .tick_o     (tick)
  );

  uart_rx_core u_core (
    .clk_i, .rst_ni,
    .en_i        (rx_on),
    .nine_bit_i,
    .rxd_i,
    .tick_i      (tick),
    .baud_clr_o  (baud_clr),
    .frame_vld_o (frame_vld),
    .frame_o     (frame)
  );

  // address filter acts only in 9-bit mode
  assign accept = !(nine_bit_i && addr_det_i && !frame.bit8);
  assign space  = !full || (rd_i && !empty);
  assign push   = frame_vld && accept && !ovr_q && space;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ovr_q <= 1'b0;
    else if (!rx_on)                                ovr_q <= 1'b0;
    else if (frame_vld && accept && !space)         ovr_q <= 1'b1;
  end

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(FRAME_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .din_i   (frame),
    .pop_i   (rd_i),
    .dout_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  assign rd_data_o = head.data;
  assign rd_bit8_o = head.bit8;
  assign rd_ferr_o = head.ferr;
  assign avail_o   = !empty;
  assign overrun_o = ovr_q;
  assign irq_o     = avail_o & irq_en_i;

  p_ovr_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> !push);
  p_ovr_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_on |=> !ovr_q);
  p_addr_filter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && nine_bit_i && addr_det_i) |-> frame.bit8);
  p_avail_after_push_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> avail_o);
endmodule

// File: tb/tb_uart_rx_addr.sv
`timescale 1ns/1ps
module tb_uart_rx_addr;
  localparam int DIV_W = 12;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rxd = 1'b1, port_en = 1'b0, rx_en = 1'b0, hi_speed = 1'b1;
  logic [DIV_W-1:0] divisor = '0;
  logic nine_bit = 1'b0, addr_det = 1'b0, irq_en = 1'b0, rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_bit8, rd_ferr, avail, overrun, irq;

  int checks = 0, fails = 0, cyc = 0, tper = 4;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_addr #(.DIV_W(DIV_W), .FIFO_DEPTH(2)) dut (
    .clk_i(clk), .rst_ni, .rxd_i(rxd), .port_en_i(port_en), .rx_en_i(rx_en),
    .hi_speed_i(hi_speed), .divisor_i(divisor), .nine_bit_i(nine_bit),
    .addr_det_i(addr_det), .irq_en_i(irq_en), .rd_i(rd),
    .rd_data_o(rd_data), .rd_bit8_o(rd_bit8), .rd_ferr_o(rd_ferr),
    .avail_o(avail), .overrun_o(overrun), .irq_o(irq)
  );

  // {nine, addr_det, data9, stop, expect_stored}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b0, 9'h0A5, 1'b1, 1'b1},  // R3
    {1'b0, 1'b0, 9'h03C, 1'b1, 1'b1},  // R3
    {1'b1, 1'b0, 9'h15A, 1'b1, 1'b1},  // R4
    {1'b1, 1'b0, 9'h081, 1'b1, 1'b1},  // R4
    {1'b1, 1'b1, 9'h122, 1'b1, 1'b1},  // R5 address frame
    {1'b1, 1'b1, 9'h077, 1'b1, 1'b0},  // R5 data frame dropped
    {1'b0, 1'b1, 9'h00F, 1'b1, 1'b1},  // R5 filter inert in 8-bit mode
    {1'b0, 1'b0, 9'h0FF, 1'b0, 1'b1}   // R6 bad stop
  };

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input bit stop);
    hold(1'b0, 16 * tper);
    for (int i = 0; i < (nine ? 9 : 8); i++) hold(d[i], 16 * tper);
    hold(stop, 16 * tper);
    hold(1'b1, 16 * tper);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_rate(input bit hs, input int dv, input int t);
    hi_speed = hs;
    divisor  = DIV_W'(dv);
    tper     = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("reset avail", avail, 0);
    chk("reset overrun", overrun, 0);
    chk("reset irq", irq, 0);

    // R2: disabled receiver ignores the line
    port_en = 1'b0; rx_en = 1'b1;
    set_rate(1'b1, 3, 4);
    send(9'h055, 1'b0, 1'b1);
    chk("R2 port_en low", avail, 0);
    port_en = 1'b1; rx_en = 1'b0;
    send(9'h055, 1'b0, 1'b1);
    chk("R2 rx_en low", avail, 0);
    rx_en = 1'b1;
    @(negedge clk);

    // vector table
    for (int v = 0; v < 8; v++) begin
      nine_bit = VEC[v][12];
      addr_det = VEC[v][11];
      @(negedge clk);
      send(VEC[v][10:2], VEC[v][12], VEC[v][1]);
      if (VEC[v][0]) begin
        chk("R3 R5 stored", avail, 1);
        chk("R3 data", rd_data, int'(VEC[v][9:2]));
        chk("R4 bit8", rd_bit8, VEC[v][12] ? int'(VEC[v][10]) : 0);
        chk("R6 ferr", rd_ferr, VEC[v][1] ? 0 : 1);
        pop();
        chk("R9 avail clears", avail, 0);
      end else begin
        chk("R5 dropped", avail, 0);
      end
    end
    nine_bit = 1'b0; addr_det = 1'b0;

    // R1: other rates
    set_rate(1'b1, 1, 2);
    send(9'h04B, 1'b0, 1'b1);
    chk("R1 hi speed div1", rd_data, 8'h4B);
    pop();
    set_rate(1'b0, 1, 8);
    send(9'h096, 1'b0, 1'b1);
    chk("R1 lo speed div1", rd_data, 8'h96);
    pop();
    set_rate(1'b0, 0, 4);

    // R6: ferr belongs to one entry
    send(9'h012, 1'b0, 1'b0);
    send(9'h034, 1'b0, 1'b1);
    chk("R6 head ferr", rd_ferr, 1);
    pop();
    chk("R6 next clean", rd_ferr, 0);
    chk("R7 order", rd_data, 8'h34);
    pop();

    // R7/R8: fill, overrun, drop, clear
    send(9'h011, 1'b0, 1'b1);
    send(9'h022, 1'b0, 1'b1);
    chk("R8 no overrun at two", overrun, 0);
    send(9'h033, 1'b0, 1'b1);
    chk("R8 overrun set", overrun, 1);
    send(9'h044, 1'b0, 1'b1);
    chk("R7 first", rd_data, 8'h11);
    pop();
    chk("R7 second", rd_data, 8'h22);
    pop();
    chk("R8 third dropped", avail, 0);
    send(9'h055, 1'b0, 1'b1);
    chk("R8 blocked while set", avail, 0);
    chk("R8 still set", overrun, 1);
    rx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 cleared", overrun, 0);
    rx_en = 1'b1;
    @(negedge clk);
    send(9'h066, 1'b0, 1'b1);
    chk("R8 accepts again", rd_data, 8'h66);

    // R9: interrupt follows enable
    irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq on", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R9 irq masked", irq, 0);
    irq_en = 1'b1;
    pop();
    chk("R9 irq after empty", irq, 0);
    irq_en = 1'b0;

    // R10: short low pulse is no start bit
    hold(1'b0, 2 * tper);
    hold(1'b1, 32 * tper);
    chk("R10 glitch rejected", avail, 0);
    send(9'h0C3, 1'b0, 1'b1);
    chk("R10 next frame", rd_data, 8'hC3);
    pop();

    // R11: short glitch inside data bit 0 near mid-bit
    hold(1'b0, 16 * tper);
    hold(1'b1, 34);
    hold(1'b0, 3);
    hold(1'b1, 16 * tper - 37);
    for (int i = 1; i < 8; i++) hold(1'b0, 16 * tper);
    hold(1'b1, 32 * tper);
    chk("R11 majority", rd_data, 8'h01);
    chk("R11 stored", avail, 1);
    pop();

    summary();
  end
endmodule